// File: doc/BRIEF.md
# Windowed Integer Register File

This block stores the integer registers of a processor core that uses sliding register windows. Software always addresses 32 registers by a 5-bit number. Eight of them are global and stay the same in every window. The other 24 are taken from a circular pool of windowed storage. A current-window pointer selects which part of that pool is visible.

There are two combinational read ports and one synchronous write port. A save strobe moves the window toward the callee and a restore strobe moves it back. The callee's incoming registers are the caller's outgoing registers, so arguments pass from caller to callee without any copying.

A window-invalid mask comes from outside the block. When a save or restore would enter a masked window, the pointer does not move and a one-cycle overflow or underflow flag is raised instead. The number of windows is a parameter, `NWIN`, from 2 to 32.

Top module: `winrf_top`

## Requirements
- R1: Register numbers 0 to 7 are globals. A global written in one window reads back with the same value after the window moves.
- R2: Register 0 always reads as zero on both read ports, and a write to it has no effect.
- R3: Register numbers 16 to 23 are locals that belong to one window only. A local written in one window does not appear in the neighbouring window, and it is intact again after returning to its own window.
- R4: The outgoing registers of a window (numbers 8 to 15) are the same storage as the incoming registers (numbers 24 to 31) of the window one below it. Register 8+k of the caller is register 24+k of the callee, in both directions.
- R5: When only save is high and the target window is not masked, the pointer goes to (cwp-1) mod NWIN. The new value shows on `cwp_o` after the next rising edge, so from 0 it goes to NWIN-1.
- R6: When only restore is high and the target window is not masked, the pointer goes to (cwp+1) mod NWIN, so from NWIN-1 it goes to 0.
- R7: If a save targets window t and `wim_i[t]` is 1, the pointer does not change. `overflow_o` is high for exactly the one cycle after that edge.
- R8: If a restore targets window t and `wim_i[t]` is 1, the pointer does not change. `underflow_o` is high for exactly the one cycle after that edge.
- R9: If save and restore are high in the same cycle, the pointer does not move and neither flag is raised.
- R10: A write in the same cycle as a save or restore is mapped through the window that was current before the move.
- R11: Reads are combinational. A write becomes visible after the rising edge that takes it, and until then a read of the same register returns the old value. The two read ports work independently. Reset clears every register to zero, sets the pointer to 0 and clears both flags.
- R12: After NWIN unmasked saves, the pointer is back where it started. Each window's local contents are still distinct and intact, so there is no aliasing between windows anywhere in the circular pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ra_addr_i | input | 5 | Read port A register number |
| ra_data_o | output | XLEN | Read port A data |
| rb_addr_i | input | 5 | Read port B register number |
| rb_data_o | output | XLEN | Read port B data |
| we_i | input | 1 | Write enable |
| w_addr_i | input | 5 | Write register number |
| w_data_i | input | XLEN | Write data |
| save_i | input | 1 | Move window down (call) |
| restore_i | input | 1 | Move window up (return) |
| wim_i | input | NWIN | Window-invalid mask, one bit per window |
| cwp_o | output | $clog2(NWIN) | Current-window pointer |
| overflow_o | output | 1 | Save was blocked by the mask |
| underflow_o | output | 1 | Restore was blocked by the mask |

## Verification
The pointer assertions sample `wim_i` in the cycle that the strobe is given. They therefore assume that the mask is valid during every strobe cycle, and that save and restore never carry X. The write-visibility assertion is only applied when the pointer did not move, because after a move the same register number maps to other storage. The stimulus changes every input on the falling edge only and holds the mask steady around each strobe. Each strobe lasts exactly one cycle, so every flag pulse and pointer step can be tied to a single edge.

// File: rtl/winrf_pkg.sv
package winrf_pkg;
  // Order of classes follows register-number bits [4:3]
  typedef enum logic [1:0] {
    RC_GLOB = 2'd0,
    RC_OUT  = 2'd1,
    RC_LOC  = 2'd2,
    RC_IN   = 2'd3
  } reg_class_e;

  function automatic reg_class_e classify(input logic [4:0] a);
    return reg_class_e'(a[4:3]);
  endfunction
endpackage

// File: rtl/winrf_map.sv
module winrf_map
  import winrf_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int CWP_W = 3,
  parameter int PW    = 7
) (
  input  logic [CWP_W-1:0] cwp_i,
  input  logic [4:0]       addr_i,
  output logic             glob_o,
  output logic [PW-1:0]    idx_o
);
  // Block of 8 regs: window w ins = 2w, locals = 2w+1, outs = ins of w-1
  logic [CWP_W-1:0] prev;
  logic [CWP_W:0]   blk;

  always_comb begin
    prev = (cwp_i == '0) ? CWP_W'(NWIN - 1) : cwp_i - 1'b1;
    unique case (classify(addr_i))
      RC_GLOB: blk = '0;
      RC_OUT:  blk = {prev, 1'b0};
      RC_LOC:  blk = {cwp_i, 1'b1};
      RC_IN:   blk = {cwp_i, 1'b0};
      default: blk = '0;
    endcase
    glob_o = (classify(addr_i) == RC_GLOB);
    idx_o  = {blk, addr_i[2:0]};
  end
endmodule

// File: rtl/winrf_cwp.sv
module winrf_cwp #(
  parameter int NWIN  = 8,
  parameter int CWP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             save_i,
  input  logic             restore_i,
  input  logic [NWIN-1:0]  wim_i,
  output logic [CWP_W-1:0] cwp_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic [CWP_W-1:0] cwp_q, dec, inc;
  logic             do_save, do_rest, blk_save, blk_rest;

  always_comb begin
    dec      = (cwp_q == '0) ? CWP_W'(NWIN - 1) : cwp_q - 1'b1;
    inc      = (cwp_q == CWP_W'(NWIN - 1)) ? '0 : cwp_q + 1'b1;
    do_save  = save_i & ~restore_i;
    do_rest  = restore_i & ~save_i;
    blk_save = do_save & wim_i[dec];
    blk_rest = do_rest & wim_i[inc];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      ovf_o <= blk_save;
      unf_o <= blk_rest;
      if (do_save && !blk_save)      cwp_q <= dec;
      else if (do_rest && !blk_rest) cwp_q <= inc;
    end
  end

  assign cwp_o = cwp_q;

  a_r5_save_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !restore_i && !wim_i[dec]) |=>
      (cwp_q == (($past(cwp_q) == '0) ? CWP_W'(NWIN - 1) : $past(cwp_q) - 1'b1)));
  a_r6_restore_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !save_i && !wim_i[inc]) |=>
      (cwp_q == (($past(cwp_q) == CWP_W'(NWIN - 1)) ? '0 : $past(cwp_q) + 1'b1)));
  a_r7_overflow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $stable(cwp_q));
  a_r8_underflow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> $stable(cwp_q));
  a_r9_both_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && restore_i) |=> ($stable(cwp_q) && !ovf_o && !unf_o));
  a_r7_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && unf_o));
endmodule

// File: rtl/winrf_store.sv
module winrf_store #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 128,
  parameter int PW    = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            w_glob_i,
  input  logic [PW-1:0]   w_idx_i,
  input  logic [XLEN-1:0] w_data_i,
  input  logic            a_glob_i,
  input  logic [PW-1:0]   a_idx_i,
  output logic [XLEN-1:0] a_data_o,
  input  logic            b_glob_i,
  input  logic [PW-1:0]   b_idx_i,
  output logic [XLEN-1:0] b_data_o
);
  logic [XLEN-1:0] glob_q [8];
  logic [XLEN-1:0] win_q  [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 8; i++) glob_q[i] <= '0;
    end else if (we_i && w_glob_i && (w_idx_i[2:0] != 3'd0)) begin
      glob_q[w_idx_i[2:0]] <= w_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) win_q[i] <= '0;
    end else if (we_i && !w_glob_i) begin
      win_q[w_idx_i] <= w_data_i;
    end
  end

  always_comb begin
    if (a_glob_i) a_data_o = (a_idx_i[2:0] == 3'd0) ? '0 : glob_q[a_idx_i[2:0]];
    else          a_data_o = win_q[a_idx_i];
    if (b_glob_i) b_data_o = (b_idx_i[2:0] == 3'd0) ? '0 : glob_q[b_idx_i[2:0]];
    else          b_data_o = win_q[b_idx_i];
  end
endmodule

// File: rtl/winrf_top.sv
module winrf_top #(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  localparam int CWP_W = $clog2(NWIN),
  localparam int PW    = CWP_W + 4,
  localparam int DEPTH = 16 * NWIN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [4:0]       ra_addr_i,
  output logic [XLEN-1:0]  ra_data_o,
  input  logic [4:0]       rb_addr_i,
  output logic [XLEN-1:0]  rb_data_o,
  input  logic             we_i,
  input  logic [4:0]       w_addr_i,
  input  logic [XLEN-1:0]  w_data_i,
  input  logic             save_i,
  input  logic             restore_i,
  input  logic [NWIN-1:0]  wim_i,
  output logic [CWP_W-1:0] cwp_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  // port 0 = write, 1 = read A, 2 = read B
  logic [4:0]    addr_p [3];
  logic          glob_p [3];
  logic [PW-1:0] idx_p  [3];

  assign addr_p[0] = w_addr_i;
  assign addr_p[1] = ra_addr_i;
  assign addr_p[2] = rb_addr_i;

  winrf_cwp #(.NWIN(NWIN), .CWP_W(CWP_W)) u_cwp (
    .clk_i, .rst_ni, .save_i, .restore_i, .wim_i,
    .cwp_o, .ovf_o(overflow_o), .unf_o(underflow_o)
  );

  for (genvar p = 0; p < 3; p++) begin : g_map
    winrf_map #(.NWIN(NWIN), .CWP_W(CWP_W), .PW(PW)) u_map (
      .cwp_i(cwp_o), .addr_i(addr_p[p]), .glob_o(glob_p[p]), .idx_o(idx_p[p])
    );
  end

  winrf_store #(.XLEN(XLEN), .DEPTH(DEPTH), .PW(PW)) u_store (
    .clk_i, .rst_ni, .we_i,
    .w_glob_i(glob_p[0]), .w_idx_i(idx_p[0]), .w_data_i,
    .a_glob_i(glob_p[1]), .a_idx_i(idx_p[1]), .a_data_o(ra_data_o),
    .b_glob_i(glob_p[2]), .b_idx_i(idx_p[2]), .b_data_o(rb_data_o)
  );

  a_r2_zero_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_addr_i == 5'd0) |-> (ra_data_o == '0));
  a_r2_zero_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_addr_i == 5'd0) |-> (rb_data_o == '0));
  a_r11_write_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && $past(w_addr_i) != 5'd0 && ra_addr_i == $past(w_addr_i)
      && cwp_o == $past(cwp_o)) |-> (ra_data_o == $past(w_data_i)));
endmodule

// File: tb/winrf_top_test.sv
module winrf_top_test;
  localparam int NWIN = 8;
  localparam int XLEN = 32;
  localparam int CW   = $clog2(NWIN);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      ra_addr = '0, rb_addr = '0, w_addr = '0;
  logic [XLEN-1:0] ra_data, rb_data, w_data = '0;
  logic            we = 1'b0, save = 1'b0, restore = 1'b0;
  logic [NWIN-1:0] wim = '0;
  logic [CW-1:0]   cwp;
  logic            ovf, unf;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  winrf_top #(.NWIN(NWIN), .XLEN(XLEN)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ra_addr_i(ra_addr), .ra_data_o(ra_data),
    .rb_addr_i(rb_addr), .rb_data_o(rb_data),
    .we_i(we), .w_addr_i(w_addr), .w_data_i(w_data),
    .save_i(save), .restore_i(restore), .wim_i(wim),
    .cwp_o(cwp), .overflow_o(ovf), .underflow_o(unf)
  );

  task automatic chk(input string req, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic rd_a(input string req, input logic [4:0] a, input logic [XLEN-1:0] exp);
    ra_addr = a; #1;
    chk(req, ra_data, exp);
  endtask

  // all stimulus tasks start and end on a falling edge
  task automatic wr(input logic [4:0] a, input logic [XLEN-1:0] d);
    we = 1'b1; w_addr = a; w_data = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_save();
    save = 1'b1; @(negedge clk); save = 1'b0;
  endtask

  task automatic do_restore();
    restore = 1'b1; @(negedge clk); restore = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 reset cwp", XLEN'(cwp), 0);
    chk("R11 reset ovf", XLEN'(ovf), 0);
    chk("R11 reset unf", XLEN'(unf), 0);
    rd_a("R11 reset r1", 5'd1, 0);
    rd_a("R11 reset r9", 5'd9, 0);
    rd_a("R11 reset r17", 5'd17, 0);
    rd_a("R11 reset r25", 5'd25, 0);
  endtask

  task automatic t_r0();
    wr(5'd0, 32'hDEAD_BEEF);
    rd_a("R2 r0 port A", 5'd0, 0);
    rb_addr = 5'd0; #1;
    chk("R2 r0 port B", rb_data, 0);
  endtask

  task automatic t_ports();
    wr(5'd5, 32'h1111_0005);
    wr(5'd6, 32'h2222_0006);
    ra_addr = 5'd5; rb_addr = 5'd6; #1;
    chk("R11 port A", ra_data, 32'h1111_0005);
    chk("R11 port B", rb_data, 32'h2222_0006);
    we = 1'b1; w_addr = 5'd5; w_data = 32'h3333_0005; #1;
    chk("R11 old before edge", ra_data, 32'h1111_0005);
    @(negedge clk); we = 1'b0;
    #1 chk("R11 new after edge", ra_data, 32'h3333_0005);
  endtask

  task automatic t_globals();
    wr(5'd3, 32'hAAAA_0003);
    do_save();
    chk("R1 cwp after save", XLEN'(cwp), 7);
    rd_a("R1 global after save", 5'd3, 32'hAAAA_0003);
    do_restore();
    rd_a("R1 global after restore", 5'd3, 32'hAAAA_0003);
  endtask

  task automatic t_share();
    wr(5'd8, 32'h0B00_0008);
    wr(5'd15, 32'h0B00_000F);
    do_save();
    rd_a("R4 out0 -> in0", 5'd24, 32'h0B00_0008);
    rd_a("R4 out7 -> in7", 5'd31, 32'h0B00_000F);
    wr(5'd26, 32'h0C00_001A);
    do_restore();
    rd_a("R4 callee in2 -> caller out2", 5'd10, 32'h0C00_001A);
  endtask

  task automatic t_locals();
    wr(5'd16, 32'h1000_0000);
    do_save();
    rd_a("R3 local hidden", 5'd16, 0);
    wr(5'd16, 32'h1000_0007);
    do_restore();
    rd_a("R3 local intact", 5'd16, 32'h1000_0000);
  endtask

  task automatic t_cwp();
    do_save();    chk("R5 0->7", XLEN'(cwp), 7);
    do_restore(); chk("R6 7->0", XLEN'(cwp), 0);
    do_restore(); chk("R6 0->1", XLEN'(cwp), 1);
    do_save();    chk("R5 1->0", XLEN'(cwp), 0);
  endtask

  task automatic t_overflow();
    wim = 8'h80;
    do_save();
    chk("R7 overflow flag", XLEN'(ovf), 1);
    chk("R7 cwp held", XLEN'(cwp), 0);
    @(negedge clk);
    chk("R7 flag one cycle", XLEN'(ovf), 0);
    wim = '0;
  endtask

  task automatic t_underflow();
    wim = 8'h02;
    do_restore();
    chk("R8 underflow flag", XLEN'(unf), 1);
    chk("R8 no overflow", XLEN'(ovf), 0);
    chk("R8 cwp held", XLEN'(cwp), 0);
    @(negedge clk);
    chk("R8 flag one cycle", XLEN'(unf), 0);
    wim = '0;
  endtask

  task automatic t_both();
    save = 1'b1; restore = 1'b1;
    @(negedge clk);
    save = 1'b0; restore = 1'b0;
    chk("R9 cwp held", XLEN'(cwp), 0);
    chk("R9 no ovf", XLEN'(ovf), 0);
    chk("R9 no unf", XLEN'(unf), 0);
  endtask

  task automatic t_same_cycle();
    save = 1'b1; we = 1'b1; w_addr = 5'd17; w_data = 32'h5A5A_0011;
    @(negedge clk);
    save = 1'b0; we = 1'b0;
    chk("R10 moved", XLEN'(cwp), 7);
    rd_a("R10 not in new window", 5'd17, 0);
    do_restore();
    rd_a("R10 in old window", 5'd17, 32'h5A5A_0011);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < NWIN; i++) begin
      wr(5'd18, 32'h7700_0000 + XLEN'(cwp));
      do_save();
    end
    chk("R12 cwp wrapped", XLEN'(cwp), 0);
    for (int i = 0; i < NWIN; i++) begin
      int ew = (NWIN - i) % NWIN;
      chk("R12 cwp seq", XLEN'(cwp), XLEN'(ew));
      rd_a("R12 local per window", 5'd18, 32'h7700_0000 + XLEN'(ew));
      do_save();
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_r0();
    t_ports();
    t_globals();
    t_share();
    t_locals();
    t_cwp();
    t_overflow();
    t_underflow();
    t_both();
    t_same_cycle();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule